// File: doc/BRIEF.md
# CAN FD Operating Mode Request Controller

This block holds the mode-control register of a CAN FD controller. Software writes a 3-bit requested mode through a simple register write port. The mode the controller is actually in appears in a separate, read-only field and on the `mode_o` output. The current mode only moves to the requested value while the protocol engine reports the bus as idle. Until then the old mode stays in place.

A few option fields are locked to the Configuration mode: writes to them take effect only while the current mode is Configuration. Outside that mode, such writes are dropped without notice. One of these locked fields selects where a system error sends the controller: Listen Only or Restricted. A system error forces this fallback mode into both the current and the requested field at once, and it overrides any pending or same-cycle request.

An abort-all bit is set by software and drives `abort_o` towards the transmit path. Hardware clears it once `all_aborted_i` reports that every pending transmission has been dropped. A read-only busy bit mirrors the inverse of the bus-idle input.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, the requested mode and the current mode both read 3'b100, and the abort bit, the fallback select and the option field read 0.
- R2: `mode_o` uses this 3-bit mode encoding: 000 Normal FD, 001 Disable, 010 Internal Loopback, 011 Listen Only, 100 Configuration, 101 External Loopback, 110 Normal Classic-only, 111 Restricted.
- R3: While `bus_idle_i` is low and `sys_err_i` is low, the current mode does not change.
- R4: At a clock edge where `bus_idle_i` is high and `sys_err_i` is low, the current mode takes the value that the requested-mode field held before that edge.
- R5: A write stores `wr_data_i[2:0]` into the requested-mode field in any mode. `rd_data_o[2:0]` reads back the requested mode and `rd_data_o[5:3]` reads the current mode.
- R6: The fallback select (bit 7) and the option field (bits 8 up to 8+OPT_W-1) are updated by a write only if the current mode is 100 at that edge. Otherwise they keep their old values.
- R7: Writing 1 to bit 6 sets the abort bit (`rd_data_o[6]`, `abort_o`) at the next edge. Writing 0 to bit 6 has no effect on it.
- R8: At an edge where `all_aborted_i` is high and no write sets bit 6, the abort bit clears.
- R9: At an edge where `sys_err_i` is high, the current mode becomes 011 if the fallback select is 1, and 111 if it is 0.
- R10: A system error also writes the fallback mode into the requested field, and it overrides a write to that field in the same cycle.
- R11: Bit 8+OPT_W of `rd_data_o` is the busy flag and reads the inverse of `bus_idle_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | OPT_W+9 | Register write data |
| rd_data_o | output | OPT_W+9 | Register read data |
| bus_idle_i | input | 1 | The protocol engine is idle, so a mode change may complete |
| sys_err_i | input | 1 | System error; forces the fallback mode |
| all_aborted_i | input | 1 | All pending transmissions have been aborted |
| mode_o | output | 3 | Current operating mode |
| abort_o | output | 1 | Abort-all request to the transmit path |

## Verification
The assertions take all inputs to be synchronous to `clk_i`, and they sample them at rising edges. They place no constraint on how inputs combine: a system error, a request write and bus idle may arrive in the same cycle, and the priority rules must cover that case. The bench changes inputs only on falling edges, so every rising edge sees settled values. It mixes directed sequences with a long pseudo-random phase. In that phase the write data is unconstrained, so mode requests land both inside and outside Configuration mode.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MODE_NORM_FD = 3'b000,
    MODE_OFF     = 3'b001,
    MODE_INT_LB  = 3'b010,
    MODE_LISTEN  = 3'b011,
    MODE_CFG     = 3'b100,
    MODE_EXT_LB  = 3'b101,
    MODE_NORM_CC = 3'b110,
    MODE_RESTR   = 3'b111
  } mode_e;

  localparam int unsigned REQ_LSB   = 0;
  localparam int unsigned CUR_LSB   = 3;
  localparam int unsigned ABORT_POS = 6;
  localparam int unsigned FB_POS    = 7;
  localparam int unsigned OPT_LSB   = 8;
endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_wr_i,
  input  mode_e req_d_i,
  input  logic  bus_idle_i,
  input  logic  sys_err_i,
  input  logic  fallback_lom_i,
  output mode_e req_o,
  output mode_e cur_o
);
  mode_e req_q, cur_q, fb_mode;

  assign fb_mode = fallback_lom_i ? MODE_LISTEN : MODE_RESTR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= MODE_CFG;
      cur_q <= MODE_CFG;
    end else if (sys_err_i) begin
      // fallback beats any request
      req_q <= fb_mode;
      cur_q <= fb_mode;
    end else begin
      if (req_wr_i)   req_q <= req_d_i;
      if (bus_idle_i) cur_q <= req_q;
    end
  end

  assign req_o = req_q;
  assign cur_o = cur_q;
endmodule

// File: rtl/can_mode_cfg.sv
module can_mode_cfg #(
  parameter int unsigned OPT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             unlocked_i,
  input  logic             fb_d_i,
  input  logic [OPT_W-1:0] opt_d_i,
  output logic             fb_o,
  output logic [OPT_W-1:0] opt_o
);
  logic             fb_q;
  logic [OPT_W-1:0] opt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q  <= 1'b0;
      opt_q <= '0;
    end else if (wr_i && unlocked_i) begin
      fb_q  <= fb_d_i;
      opt_q <= opt_d_i;
    end
  end

  assign fb_o  = fb_q;
  assign opt_o = opt_q;
endmodule

// File: rtl/can_mode_abort.sv
module can_mode_abort (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic abort_o
);
  logic abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     abort_q <= 1'b0;
    else if (set_i)  abort_q <= 1'b1;
    else if (done_i) abort_q <= 1'b0;
  end

  assign abort_o = abort_q;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned OPT_W = 6,
  localparam int unsigned BUSY_POS = OPT_LSB + OPT_W,
  localparam int unsigned DW       = BUSY_POS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          bus_idle_i,
  input  logic          sys_err_i,
  input  logic          all_aborted_i,
  output logic [2:0]    mode_o,
  output logic          abort_o
);
  mode_e            req_mode, cur_mode;
  logic             fb_lom, abort_q;
  logic [OPT_W-1:0] opt_q;

  can_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_wr_i      (wr_en_i),
    .req_d_i       (mode_e'(wr_data_i[REQ_LSB +: 3])),
    .bus_idle_i    (bus_idle_i),
    .sys_err_i     (sys_err_i),
    .fallback_lom_i(fb_lom),
    .req_o         (req_mode),
    .cur_o         (cur_mode)
  );

  can_mode_cfg #(.OPT_W(OPT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .unlocked_i(cur_mode == MODE_CFG),
    .fb_d_i    (wr_data_i[FB_POS]),
    .opt_d_i   (wr_data_i[OPT_LSB +: OPT_W]),
    .fb_o      (fb_lom),
    .opt_o     (opt_q)
  );

  can_mode_abort u_abort (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_en_i && wr_data_i[ABORT_POS]),
    .done_i (all_aborted_i),
    .abort_o(abort_q)
  );

  assign rd_data_o = {~bus_idle_i, opt_q, fb_lom, abort_q, cur_mode, req_mode};
  assign mode_o    = cur_mode;
  assign abort_o   = abort_q;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
  parameter int unsigned OPT_W = 6,
  localparam int unsigned BUSY_POS = 8 + OPT_W,
  localparam int unsigned DW       = BUSY_POS + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] rd_data_o,
  input logic          bus_idle_i,
  input logic          sys_err_i,
  input logic          all_aborted_i,
  input logic [2:0]    mode_o,
  input logic          abort_o
);
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_idle_i && !sys_err_i) |=> $stable(mode_o)); // R3
  AST_FOLLOW_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && !sys_err_i) |=> mode_o == $past(rd_data_o[2:0])); // R4
  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'b100) |=> $stable(rd_data_o[BUSY_POS-1:7])); // R6
  AST_ABORT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[6]) |=> abort_o); // R7
  AST_ABORT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_aborted_i && !(wr_en_i && wr_data_i[6])) |=> !abort_o); // R8
  AST_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_i |=> mode_o == ($past(rd_data_o[7]) ? 3'b011 : 3'b111)); // R9
  AST_FALLBACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_i |=> rd_data_o[2:0] == mode_o); // R10
endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.OPT_W(OPT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .bus_idle_i   (bus_idle_i),
  .sys_err_i    (sys_err_i),
  .all_aborted_i(all_aborted_i),
  .mode_o       (mode_o),
  .abort_o      (abort_o)
);

// File: tb/sim_can_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_mode_ctrl;
  localparam int OPT_W = 6;
  localparam int DW    = OPT_W + 9;
  localparam int BUSY  = OPT_W + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          bus_idle = 1'b0;
  logic          sys_err = 1'b0;
  logic          all_ab = 1'b0;
  logic [2:0]    mode;
  logic          abort;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_req, m_cur, m_ab, m_fb, m_opt;

  always #2.5 clk = ~clk;

  can_mode_ctrl #(.OPT_W(OPT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .bus_idle_i(bus_idle), .sys_err_i(sys_err),
    .all_aborted_i(all_ab), .mode_o(mode), .abort_o(abort)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 4; m_cur = 4; m_ab = 0; m_fb = 0; m_opt = 0;
    end else begin
      int n_req, n_cur;
      n_req = m_req; n_cur = m_cur;
      if (sys_err) begin
        n_cur = m_fb ? 3 : 7;
        n_req = n_cur;
      end else begin
        if (bus_idle) n_cur = m_req;
        if (wr_en) n_req = int'(wr_data[2:0]);
      end
      if (wr_en && m_cur == 4) begin
        m_fb  = int'(wr_data[7]);
        m_opt = int'(wr_data[8 +: OPT_W]);
      end
      if (wr_en && wr_data[6]) m_ab = 1;
      else if (all_ab) m_ab = 0;
      m_req = n_req; m_cur = n_cur;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 mode_o",        int'(mode), m_cur);
    chk("R5 req field",     int'(rd_data[2:0]), m_req);
    chk("R5 cur field",     int'(rd_data[5:3]), m_cur);
    chk("R7 abort_o",       int'(abort), m_ab);
    chk("R8 abort field",   int'(rd_data[6]), m_ab);
    chk("R6 fallback sel",  int'(rd_data[7]), m_fb);
    chk("R6 option field",  int'(rd_data[8 +: OPT_W]), m_opt);
    chk("R11 busy",         int'(rd_data[BUSY]), bus_idle ? 0 : 1);
  endtask

  // compare at falling edge, then drive the next cycle's inputs
  task automatic step(bit w, logic [DW-1:0] d, bit idle, bit err, bit ab);
    @(negedge clk);
    compare_all();
    wr_en = w; wr_data = d; bus_idle = idle; sys_err = err; all_ab = ab;
  endtask

  function automatic logic [DW-1:0] word(int req, bit ab, bit fb, int opt);
    logic [DW-1:0] v;
    v = '0;
    v[2:0] = 3'(req);
    v[6] = ab;
    v[7] = fb;
    v[8 +: OPT_W] = OPT_W'(opt);
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #10;
    // R1 reset state
    chk("R1 mode after reset", int'(mode), 4);
    chk("R1 req after reset",  int'(rd_data[2:0]), 4);
    chk("R1 abort after reset", int'(abort), 0);
    chk("R1 cfg after reset",  int'(rd_data[BUSY-1:7]), 0);
    @(negedge clk) rst_n = 1'b1;

    // R6 config fields writable in Configuration mode
    step(1, word(4, 0, 1, 21), 0, 0, 0);
    step(0, '0, 0, 0, 0);
    chk("R6 fb written in cfg", int'(rd_data[7]), 1);
    chk("R6 opt written in cfg", int'(rd_data[8 +: OPT_W]), 21);
    // R5/R3 request Normal FD while busy
    step(1, word(0, 0, 1, 21), 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 0, 0, 0);
    chk("R3 mode held while busy", int'(mode), 4);
    chk("R5 request stored", int'(rd_data[2:0]), 0);
    // R4 follow on idle
    step(0, '0, 1, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R4 mode follows on idle", int'(mode), 0);
    // R6 locked outside cfg
    step(1, word(0, 0, 0, 9), 1, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R6 fb locked", int'(rd_data[7]), 1);
    chk("R6 opt locked", int'(rd_data[8 +: OPT_W]), 21);
    // R7/R8 abort
    step(1, word(0, 1, 0, 0), 1, 0, 0);
    step(1, word(0, 0, 0, 0), 1, 0, 0);
    step(0, '0, 1, 0, 0);
    chk("R7 abort set, zero write ignored", int'(abort), 1);
    step(1, word(0, 1, 0, 0), 1, 0, 1);
    step(0, '0, 1, 0, 1);
    chk("R8 set wins over clear", int'(abort), 1);
    step(0, '0, 1, 0, 0);
    chk("R8 abort cleared", int'(abort), 0);
    // R9 fallback to Listen Only
    step(0, '0, 0, 1, 0);
    step(0, '0, 0, 0, 0);
    chk("R9 listen only fallback", int'(mode), 3);
    // back to cfg, clear fallback select
    step(1, word(4, 0, 0, 0), 1, 0, 0);
    step(0, '0, 1, 0, 0);
    step(1, word(4, 0, 0, 5), 0, 0, 0);
    // R10 sys err overrides simultaneous write
    step(1, word(2, 0, 0, 5), 1, 1, 0);
    step(0, '0, 0, 0, 0);
    chk("R9 restricted fallback", int'(mode), 7);
    chk("R10 req overridden", int'(rd_data[2:0]), 7);
    // R2 walk every encoding
    for (int m = 0; m < 8; m++) begin
      step(1, word(m, 0, 0, 0), 1, 0, 0);
      step(0, '0, 1, 0, 0);
      step(0, '0, 1, 0, 0);
      chk("R2 mode encoding", int'(mode), m);
    end
    // pseudo-random phase
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      step(($urandom % 3) == 0, d, ($urandom % 2) == 0,
           ($urandom % 40) == 0, ($urandom % 4) == 0);
    end
    step(0, '0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule